// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timing Generator

This block turns a fast reference clock into the serial clock and the four active-low chip-select lines of a serial flash master. A control word carries an enable bit, the clock polarity and phase, a select-decode flag, a 4-bit select field and a 4-bit divisor. A second word packs four 8-bit gaps, all counted in reference cycles: select-to-first-edge, last-edge-to-deselect, the extra idle time needed when the next transfer targets a different device, and the minimum deselected time between transfers.

A one-cycle `start_i` pulse begins a transfer. The block waits until the deselected time is long enough, drives the select lines and waits the setup gap. It then emits `len_i` full serial clock periods, waits the hold gap, releases the select lines and pulses `done_o`. Shifting of data is left to a separate shifter, which is told when to sample and when to shift by one-cycle strobes. All settings are taken from the inputs when a transfer starts, and are then held for the whole transfer.

Control word layout: bit 0 enable, bit 1 polarity, bit 2 phase, bit 3 decode, bits [7:4] select, bits [11:8] divisor N. Gap word layout: [7:0] setup, [15:8] hold, [23:16] device switch, [31:24] minimum deselected time.

Top module: `sclk_cs_timer`

## Requirements
- R1: After reset `cs_n_o` is 4'b1111, `sclk_o` is 0, `idle_o` is 1 and `done_o` is 0.
- R2: During a transfer `sclk_o` toggles exactly 2*len times, every N+1 reference cycles after the first toggle. Between transfers it rests at the polarity level, and it ends the transfer at that level.
- R3: The first `sclk_o` toggle comes max(setup,1) reference cycles after the select lines go active.
- R4: The select lines are released max(hold,1) reference cycles after the last `sclk_o` toggle.
- R5: The select lines become active no sooner than max(G,1) cycles after they were last released. G is the minimum deselected time, raised to the switch gap when the new select pattern differs from the previous one. When start is raised in the cycle that `done_o` is seen, the deselected time is exactly max(G,1).
- R6: With decode at 0 the active select pattern is all ones except bit sel[1:0], and sel[3:2] is ignored. With decode at 1 the pattern is the raw 4-bit select code. The pattern is constant for the whole transfer.
- R7: Every `sclk_o` toggle comes with exactly one strobe in the same cycle. A toggle away from the polarity level is a leading edge. With phase 0 leading edges give `sample_stb_o` and trailing edges give `shift_stb_o`; with phase 1 the two are swapped. Each strobe therefore occurs len times per transfer.
- R8: While enable is 0 a start pulse is ignored. Clearing enable during a transfer ends the transfer at the next clock edge: select lines released, `sclk_o` at the polarity level, `idle_o` high, and no `done_o`.
- R9: Changing the control word, gap word or length while a transfer is in progress does not affect that transfer.
- R10: With length 0 no `sclk_o` toggle occurs, and the select lines stay active for max(setup,1)+max(hold,1) cycles.
- R11: `done_o` is a one-cycle pulse in the first cycle in which the select lines are released. `idle_o` is 0 from the cycle after start is accepted until that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 12 | Control word: enable, polarity, phase, decode, select, divisor |
| gap_i | input | 4*DLY_W | Packed setup, hold, switch and deselected-time gaps |
| len_i | input | LEN_W | Number of serial clock periods per transfer |
| start_i | input | 1 | One-cycle request to begin a transfer |
| done_o | output | 1 | One-cycle pulse when the select lines are released |
| idle_o | output | 1 | High when no transfer is pending or active |
| sclk_o | output | 1 | Serial clock |
| sample_stb_o | output | 1 | Strobe to the shifter: capture input data |
| shift_stb_o | output | 1 | Strobe to the shifter: advance output data |
| cs_n_o | output | 4 | Active-low select lines or select code |

## Verification
The embedded properties assume that enable may fall in any cycle. They also assume that the control inputs settle before the clock edge at which start is sampled, so the snapshot they check is well defined. The bench changes inputs only on falling clock edges. It raises start only when the block is idle or in the cycle that `done_o` is seen. It keeps every length at or below a few periods, so each divisor setting finishes well inside the run. Mid-transfer edits of the divisor and length are made deliberately, to show that the snapshot holds.

// File: rtl/sclk_cs_timer.sv
module sclk_cs_timer #(
  parameter int DLY_W = 8,
  parameter int LEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        cfg_i,
  input  logic [4*DLY_W-1:0] gap_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               start_i,
  output logic               done_o,
  output logic               idle_o,
  output logic               sclk_o,
  output logic               sample_stb_o,
  output logic               shift_stb_o,
  output logic [3:0]         cs_n_o
);

  localparam logic [DLY_W-1:0] ONE_D = 1;
  localparam logic [LEN_W:0]   ONE_E = 1;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SETUP, S_RUN, S_HOLD} st_t;

  st_t                st;
  logic [11:1]        cfg_q;
  logic [4*DLY_W-1:0] gap_q;
  logic [LEN_W-1:0]   len_q;
  logic [DLY_W-1:0]   cnt, hi_cnt;
  logic [3:0]         dcnt, cs_n_q, last_pat;
  logic [LEN_W:0]     ecnt;
  logic               sclk_q, done_q, lead_q, trail_q;

  wire en      = cfg_i[0];
  wire in_idle = (st == S_IDLE);

  wire [11:1]        cfg_c = in_idle ? cfg_i[11:1] : cfg_q;
  wire [4*DLY_W-1:0] gap_c = in_idle ? gap_i : gap_q;
  wire [LEN_W-1:0]   len_c = in_idle ? len_i : len_q;

  wire       cpol_c = cfg_c[1];
  wire       cpha_c = cfg_c[2];
  wire       dec_c  = cfg_c[3];
  wire [3:0] sel_c  = cfg_c[7:4];
  wire [3:0] baud_c = cfg_c[11:8];

  wire [DLY_W-1:0] t_setup  = gap_c[DLY_W-1:0];
  wire [DLY_W-1:0] t_hold   = gap_c[2*DLY_W-1:DLY_W];
  wire [DLY_W-1:0] t_switch = gap_c[3*DLY_W-1:2*DLY_W];
  wire [DLY_W-1:0] t_high   = gap_c[4*DLY_W-1:3*DLY_W];

  wire [3:0] pat_c = dec_c ? sel_c : ~(4'b0001 << sel_c[1:0]);

  logic [DLY_W-1:0] need;
  logic [DLY_W:0]   hi_p1;
  assign need   = (pat_c != last_pat && t_switch > t_high) ? t_switch : t_high;
  assign hi_p1  = {1'b0, hi_cnt} + {{DLY_W{1'b0}}, 1'b1};
  wire   gap_ok = hi_p1 >= {1'b0, need};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cfg_q    <= '0;
      gap_q    <= '0;
      len_q    <= '0;
      cnt      <= '0;
      dcnt     <= '0;
      ecnt     <= '0;
      sclk_q   <= 1'b0;
      cs_n_q   <= '1;
      last_pat <= '1;
      hi_cnt   <= '1;
      done_q   <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (&cs_n_q) hi_cnt <= (&hi_cnt) ? hi_cnt : hi_cnt + ONE_D;
      else         hi_cnt <= '0;

      if (!en) begin
        st     <= S_IDLE;
        cs_n_q <= '1;
        sclk_q <= cfg_i[1];
      end else begin
        case (st)
          S_IDLE: begin
            sclk_q <= cfg_i[1];
            if (start_i) begin
              cfg_q <= cfg_i[11:1];
              gap_q <= gap_i;
              len_q <= len_i;
              if (gap_ok) begin
                cs_n_q   <= pat_c;
                last_pat <= pat_c;
                cnt      <= t_setup;
                st       <= S_SETUP;
              end else begin
                st <= S_GAP;
              end
            end
          end
          S_GAP: begin
            if (gap_ok) begin
              cs_n_q   <= pat_c;
              last_pat <= pat_c;
              cnt      <= t_setup;
              st       <= S_SETUP;
            end
          end
          S_SETUP: begin
            if (cnt <= ONE_D) begin
              if (len_c == '0) begin
                cnt <= t_hold;
                st  <= S_HOLD;
              end else begin
                sclk_q  <= ~sclk_q;
                lead_q  <= (sclk_q == cpol_c);
                trail_q <= (sclk_q != cpol_c);
                dcnt    <= baud_c;
                ecnt    <= {len_c, 1'b0} - ONE_E;
                st      <= S_RUN;
              end
            end else begin
              cnt <= cnt - ONE_D;
            end
          end
          S_RUN: begin
            if (dcnt != 4'd0) begin
              dcnt <= dcnt - 4'd1;
            end else begin
              sclk_q  <= ~sclk_q;
              lead_q  <= (sclk_q == cpol_c);
              trail_q <= (sclk_q != cpol_c);
              dcnt    <= baud_c;
              ecnt    <= ecnt - ONE_E;
              if (ecnt == ONE_E) begin
                cnt <= t_hold;
                st  <= S_HOLD;
              end
            end
          end
          S_HOLD: begin
            if (cnt <= ONE_D) begin
              cs_n_q <= '1;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              cnt <= cnt - ONE_D;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sclk_o       = sclk_q;
  assign cs_n_o       = cs_n_q;
  assign done_o       = done_q;
  assign idle_o       = in_idle;
  assign sample_stb_o = cpha_c ? trail_q : lead_q;
  assign shift_stb_o  = cpha_c ? lead_q : trail_q;

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (&cs_n_o));

  a_r2_half_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && dcnt != 4'd0 && en) |=> $stable(sclk_o));

  a_r3_quiet_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP && cnt > ONE_D && en) |=> $stable(sclk_o));

  a_r6_one_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !dec_c && !(&cs_n_o)) |-> ($countones(cs_n_o) == 3));

  a_r6_pattern_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && en) |=> $stable(cs_n_o));

  a_r7_strobe_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb_o || shift_stb_o) |-> !$stable(sclk_o));

  a_r11_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((&cs_n_o) && idle_o));

endmodule

// File: tb/sclk_cs_timer_tb_top.sv
module sclk_cs_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_r = '0;
  logic [31:0] gap_r = '0;
  logic [7:0]  len_r = '0;
  logic        start_r = 1'b0;
  logic        done_o, idle_o, sclk_o, sample_stb_o, shift_stb_o;
  logic [3:0]  cs_n_o;

  always #4 clk = ~clk;

  sclk_cs_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_r), .gap_i(gap_r), .len_i(len_r),
    .start_i(start_r), .done_o(done_o), .idle_o(idle_o), .sclk_o(sclk_o),
    .sample_stb_o(sample_stb_o), .shift_stb_o(shift_stb_o), .cs_n_o(cs_n_o));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct packed {
    logic [3:0] baud;
    logic       cpol, cpha, dec;
    logic [3:0] sel1, sel2;
    logic [7:0] setup, hold, sw, high, len;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{4'd0,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd1, 8'd1, 8'd5,  8'd3,  8'd4},
    '{4'd3,  1'b1, 1'b0, 1'b0, 4'd1, 4'd2, 8'd4, 8'd2, 8'd9,  8'd2,  8'd3},
    '{4'd15, 1'b0, 1'b1, 1'b0, 4'd3, 4'd3, 8'd0, 8'd0, 8'd20, 8'd0,  8'd2},
    '{4'd1,  1'b1, 1'b1, 1'b1, 4'd5, 4'd9, 8'd7, 8'd5, 8'd4,  8'd12, 8'd5},
    '{4'd2,  1'b0, 1'b0, 1'b1, 4'd2, 4'd2, 8'd2, 8'd10,8'd30, 8'd6,  8'd1},
    '{4'd7,  1'b0, 1'b1, 1'b0, 4'd2, 4'd0, 8'd3, 8'd3, 8'd2,  8'd1,  8'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic logic [3:0] pat_of(input logic dec, input logic [3:0] sel);
    return dec ? sel : ~(4'b0001 << sel[1:0]);
  endfunction

  task automatic do_xfer(input logic [3:0] sel, input int poke_at,
                         output int a_i, output int d_i);
    int e_baud, e_setup, e_hold, e_len;
    logic e_cpol, e_cpha;
    logic [3:0] e_pat;
    int changes, first_c, last_c, hp_bad, samp, shft, sbad, pbad;
    logic prev;
    bit got, first_samp;
    cfg_r[7:4] = sel;
    e_baud  = int'(cfg_r[11:8]);
    e_cpol  = cfg_r[1];
    e_cpha  = cfg_r[2];
    e_pat   = pat_of(cfg_r[3], sel);
    e_setup = int'(gap_r[7:0]);
    e_hold  = int'(gap_r[15:8]);
    e_len   = int'(len_r);
    changes = 0; first_c = 0; last_c = 0; hp_bad = 0; samp = 0; shft = 0;
    sbad = 0; pbad = 0; got = 0; first_samp = 0;
    a_i = -1; d_i = -1;
    chk("R2 sclk rests at polarity", int'(sclk_o), int'(e_cpol));
    prev = sclk_o;
    start_r = 1'b1;
    tick();
    start_r = 1'b0;
    for (int iter = 0; iter < 5000; iter++) begin
      if (iter == poke_at) begin
        cfg_r[11:8] = ~cfg_r[11:8];
        len_r = len_r + 8'd3;
      end
      if (a_i < 0 && cs_n_o != 4'hF) begin
        a_i = cyc;
        chk("R11 idle low during transfer", int'(idle_o), 0);
      end
      if (a_i >= 0 && cs_n_o != 4'hF && cs_n_o != e_pat) pbad++;
      if ((sample_stb_o || shift_stb_o) != (sclk_o != prev)) sbad++;
      if (!got && (sample_stb_o || shift_stb_o)) begin
        got = 1;
        first_samp = sample_stb_o;
      end
      samp += int'(sample_stb_o);
      shft += int'(shift_stb_o);
      if (sclk_o != prev) begin
        if (changes == 0) first_c = cyc;
        else if (cyc - last_c != e_baud + 1) hp_bad++;
        last_c = cyc;
        changes++;
        prev = sclk_o;
      end
      if (done_o) begin
        d_i = cyc;
        break;
      end
      tick();
    end
    chk("R11 done seen", int'(d_i >= 0), 1);
    chk("R11 released with done", int'(cs_n_o), 15);
    chk("R6 select pattern", pbad, 0);
    chk("R2 toggle count", changes, 2 * e_len);
    chk("R7 strobe per edge", sbad, 0);
    if (e_len == 0) begin
      chk("R10 zero length active time", d_i - a_i, atleast1(e_setup) + atleast1(e_hold));
    end else begin
      chk("R2 half period", hp_bad, 0);
      chk("R2 ends at polarity", int'(sclk_o), int'(e_cpol));
      chk("R3 setup gap", first_c - a_i, atleast1(e_setup));
      chk("R4 hold gap", d_i - last_c, atleast1(e_hold));
      chk("R7 sample count", samp, e_len);
      chk("R7 shift count", shft, e_len);
      chk("R7 first strobe kind", int'(first_samp), int'(!e_cpha));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int a1, d1, a2, d2, need, hits;
    logic [3:0] p1, p2;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 cs released", int'(cs_n_o), 15);
    chk("R1 sclk low", int'(sclk_o), 0);
    chk("R1 idle", int'(idle_o), 1);
    chk("R1 no done", int'(done_o), 0);

    foreach (VECS[i]) begin
      cfg_r = {VECS[i].baud, 4'd0, VECS[i].dec, VECS[i].cpha, VECS[i].cpol, 1'b1};
      gap_r = {VECS[i].high, VECS[i].sw, VECS[i].hold, VECS[i].setup};
      len_r = VECS[i].len;
      repeat (300) tick();
      do_xfer(VECS[i].sel1, -1, a1, d1);
      do_xfer(VECS[i].sel2, -1, a2, d2);
      p1 = pat_of(VECS[i].dec, VECS[i].sel1);
      p2 = pat_of(VECS[i].dec, VECS[i].sel2);
      need = int'(VECS[i].high);
      if (p1 != p2 && int'(VECS[i].sw) > need) need = int'(VECS[i].sw);
      chk("R5 deselected gap", a2 - d1, atleast1(need));
      tick();
      chk("R11 done single cycle", int'(done_o), 0);
    end

    // R8 start ignored while disabled
    cfg_r[0] = 1'b0;
    repeat (300) tick();
    start_r = 1'b1;
    tick();
    start_r = 1'b0;
    hits = 0;
    repeat (20) begin
      tick();
      if (cs_n_o != 4'hF || !idle_o) hits++;
    end
    chk("R8 start ignored when disabled", hits, 0);

    // R8 abort by clearing enable
    cfg_r = {4'd3, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1};
    gap_r = {8'd1, 8'd1, 8'd2, 8'd2};
    len_r = 8'd8;
    repeat (5) tick();
    start_r = 1'b1;
    tick();
    start_r = 1'b0;
    repeat (15) tick();
    chk("R8 transfer running before abort", int'(cs_n_o), 13);
    cfg_r[0] = 1'b0;
    tick();
    chk("R8 abort releases select", int'(cs_n_o), 15);
    chk("R8 abort sclk at polarity", int'(sclk_o), 1);
    chk("R8 abort idle", int'(idle_o), 1);
    hits = 0;
    repeat (30) begin
      if (done_o) hits++;
      tick();
    end
    chk("R8 no done after abort", hits, 0);

    // R9 mid-transfer edits ignored
    cfg_r = {4'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1};
    gap_r = {8'd1, 8'd1, 8'd2, 8'd2};
    len_r = 8'd4;
    repeat (300) tick();
    do_xfer(4'd3, 6, a1, d1);
    chk("R9 length kept despite edit", (d1 - a1), 2 + 7 * 3 + 2);

    // R10 zero length
    cfg_r = {4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1};
    gap_r = {8'd1, 8'd1, 8'd4, 8'd3};
    len_r = 8'd0;
    repeat (300) tick();
    do_xfer(4'd1, -1, a1, d1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule